// File: doc/BRIEF.md
# Masked Pattern and Change Trigger

This block watches a 32-bit parallel input port and decides, sample by sample, which words are captured and when an acquisition begins and ends. A sample is offered by pulsing `smp_en` for one clock with the word on `smp_data`. A word that is accepted comes out one clock later on `cap_data`, qualified by `cap_valid`. The output stream has no ready signal and cannot be stalled, so the consumer must take every beat. Configuration inputs must stay stable while `arm` is high.

There are two capture qualifiers. In free-run mode every sample taken during the acquisition is captured. In change mode a sample is captured only when a line selected by `cfg_mask` differs from the previous sample. The whole word is captured in that case, the masked lines included. The same mask also selects the lines that the pattern comparator examines.

An acquisition may wait for an external start edge, which is synchronised to the sample strobe. It ends on a stop event, which is either an external edge or a pattern match or mismatch. After the stop event the block captures a set number of posttrigger samples and then raises `done`. If the stop event comes before enough pretrigger samples have been captured, the block raises `err` and `done` together.

Top module: `masked_trig_top`

## Requirements
- R1: While `arm` is low, and in the clock after it falls, `cap_valid`, `done` and `err` are all 0.
- R2: Each capture appears as `cap_valid`=1 for exactly one clock, in the clock right after the accepting strobe, with `cap_data` equal to the full 32-bit sample.
- R3: When `cfg_change_mode`=1, the first strobe after arming only loads the previous-sample register. A later sample is captured only if `((data ^ previous) & cfg_mask) != 0`.
- R4: When `cfg_stop_pattern`=1, a strobe whose sample has `((data ^ cfg_pattern) & cfg_mask) == 0` is the stop event if `cfg_mismatch`=0. If `cfg_mismatch`=1, a strobe whose sample gives a nonzero result is the stop event. The stop strobe itself is never captured.
- R5: Each external trigger input reacts to its rising edge when its select bit is 0 (`cfg_start_fall`, `cfg_stop_fall`) and to its falling edge when that bit is 1. A one-clock pulse is seen, and an edge of the wrong polarity has no effect.
- R6: When `cfg_use_start`=1, nothing is captured before the start edge or at the first strobe after it. Capture begins at the second strobe after the start edge.
- R7: A stop edge that arrives while the block is still waiting for its start trigger is discarded and does not stop the later acquisition.
- R8: After a stop event the block captures `cfg_post` further qualifying samples and raises `done` in the same clock as the last one. No capture follows while `done` is high.
- R9: If the number of captured pretrigger samples is below `cfg_pre` when the stop event occurs, `err` and `done` rise together and no further sample is captured.
- R10: Lines outside `cfg_mask` affect neither change detection nor the pattern comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | High runs an acquisition; low clears the block |
| smp_en | input | 1 | Sample strobe, one clock per sample |
| smp_data | input | 32 | Sampled port word |
| cfg_mask | input | 32 | Significant-line mask for change and pattern |
| cfg_pattern | input | 32 | Pattern compared on masked lines |
| cfg_change_mode | input | 1 | 1: capture only on change; 0: capture every sample |
| cfg_mismatch | input | 1 | 1: pattern event on mismatch; 0: on match |
| cfg_use_start | input | 1 | 1: wait for external start edge |
| cfg_stop_pattern | input | 1 | 1: stop on pattern event; 0: stop on external edge |
| cfg_start_fall | input | 1 | Start edge select, 1 = falling |
| cfg_stop_fall | input | 1 | Stop edge select, 1 = falling |
| ext_start | input | 1 | External start trigger |
| ext_stop | input | 1 | External stop trigger |
| cfg_pre | input | 16 | Required pretrigger sample count |
| cfg_post | input | 16 | Posttrigger sample count |
| cap_valid | output | 1 | Captured word valid (no back-pressure) |
| cap_data | output | 32 | Captured word |
| done | output | 1 | Acquisition finished |
| err | output | 1 | Pretrigger shortfall |

## Verification
A wrong sequencer state shows up at `cap_valid` one clock after the next strobe, as a word that is missing or a word that is too many. A stray pending start or stop shows up at the strobe where the lag or the ignore rule should have applied. A stale previous-sample register or a bad mask term changes which words are captured at the very next strobe, and it moves the stop point by at least one word. Counter faults become visible at the clock where `done` or `err` rises, since each is compared against the exact strobe at which it is expected.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_ACQ,
    SQ_POST,
    SQ_DONE
  } seq_state_t;
endpackage

// File: rtl/trig_edge.sv
module trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic fall,
  output logic pulse
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign pulse = fall ? (lvl_q & ~lvl) : (~lvl_q & lvl);
endmodule

// File: rtl/trig_compare.sv
module trig_compare #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         smp_en,
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] pattern,
  input  logic         mismatch,
  output logic         changed,
  output logic         pat_fire
);
  logic [W-1:0] prev_q;
  logic         primed_q;
  logic [W-1:0] diff_prev;
  logic [W-1:0] diff_pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (clear) begin
      primed_q <= 1'b0;
    end else if (smp_en) begin
      prev_q   <= data;
      primed_q <= 1'b1;
    end
  end

  assign diff_prev = (data ^ prev_q) & mask;
  assign diff_pat  = (data ^ pattern) & mask;
  assign changed   = primed_q & (|diff_prev);
  assign pat_fire  = mismatch ? (|diff_pat) : ~(|diff_pat);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          smp_en,
  input  logic [W-1:0]  smp_data,
  input  logic          changed,
  input  logic          pat_fire,
  input  logic          start_edge,
  input  logic          stop_edge,
  input  logic          cfg_change_mode,
  input  logic          cfg_use_start,
  input  logic          cfg_stop_pattern,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  output logic          cap_valid,
  output logic [W-1:0]  cap_data,
  output logic          done,
  output logic          err
);
  localparam logic [CW-1:0] ONE = CW'(1);

  seq_state_t    state;
  logic [CW-1:0] pre_cnt;
  logic [CW-1:0] post_cnt;
  logic          start_pend;
  logic          stop_pend;
  logic          qual;
  logic          stop_now;

  assign qual     = cfg_change_mode ? changed : 1'b1;
  assign stop_now = cfg_stop_pattern ? pat_fire : stop_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      pre_cnt    <= '0;
      post_cnt   <= '0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      cap_valid  <= 1'b0;
      cap_data   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      if (!arm) begin
        state      <= SQ_IDLE;
        done       <= 1'b0;
        err        <= 1'b0;
        start_pend <= 1'b0;
        stop_pend  <= 1'b0;
      end else begin
        case (state)
          SQ_IDLE: begin
            pre_cnt    <= '0;
            post_cnt   <= '0;
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
            state      <= cfg_use_start ? SQ_WAIT : SQ_ACQ;
          end
          SQ_WAIT: begin
            if (smp_en && start_pend) begin
              start_pend <= 1'b0;
              state      <= SQ_ACQ;
            end else if (start_edge) begin
              start_pend <= 1'b1;
            end
          end
          SQ_ACQ: begin
            if (stop_edge && !cfg_stop_pattern) stop_pend <= 1'b1;
            if (smp_en) begin
              if (stop_now) begin
                stop_pend <= 1'b0;
                if (pre_cnt < cfg_pre) begin
                  err   <= 1'b1;
                  done  <= 1'b1;
                  state <= SQ_DONE;
                end else if (cfg_post == '0) begin
                  done  <= 1'b1;
                  state <= SQ_DONE;
                end else begin
                  state <= SQ_POST;
                end
              end else if (qual) begin
                cap_valid <= 1'b1;
                cap_data  <= smp_data;
                if (pre_cnt != '1) pre_cnt <= pre_cnt + ONE;
              end
            end
          end
          SQ_POST: begin
            if (smp_en && qual) begin
              cap_valid <= 1'b1;
              cap_data  <= smp_data;
              post_cnt  <= post_cnt + ONE;
              if ((post_cnt + ONE) == cfg_post) begin
                done  <= 1'b1;
                state <= SQ_DONE;
              end
            end
          end
          SQ_DONE: ;
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/masked_trig_top.sv
module masked_trig_top #(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          smp_en,
  input  logic [W-1:0]  smp_data,
  input  logic [W-1:0]  cfg_mask,
  input  logic [W-1:0]  cfg_pattern,
  input  logic          cfg_change_mode,
  input  logic          cfg_mismatch,
  input  logic          cfg_use_start,
  input  logic          cfg_stop_pattern,
  input  logic          cfg_start_fall,
  input  logic          cfg_stop_fall,
  input  logic          ext_start,
  input  logic          ext_stop,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  output logic          cap_valid,
  output logic [W-1:0]  cap_data,
  output logic          done,
  output logic          err
);
  logic start_edge;
  logic stop_edge;
  logic changed;
  logic pat_fire;

  trig_edge u_start_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ext_start), .fall(cfg_start_fall), .pulse(start_edge)
  );
  trig_edge u_stop_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ext_stop), .fall(cfg_stop_fall), .pulse(stop_edge)
  );

  trig_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(~arm), .smp_en(smp_en), .data(smp_data),
    .mask(cfg_mask), .pattern(cfg_pattern), .mismatch(cfg_mismatch),
    .changed(changed), .pat_fire(pat_fire)
  );

  trig_seq #(.W(W), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .smp_data(smp_data),
    .changed(changed), .pat_fire(pat_fire), .start_edge(start_edge), .stop_edge(stop_edge),
    .cfg_change_mode(cfg_change_mode), .cfg_use_start(cfg_use_start),
    .cfg_stop_pattern(cfg_stop_pattern), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .cap_valid(cap_valid), .cap_data(cap_data), .done(done), .err(err)
  );
endmodule

// File: rtl/masked_trig_chk.sv
module masked_trig_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic smp_en,
  input logic cap_valid,
  input logic done,
  input logic err
);
  assert_disarm_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!cap_valid && !done && !err));

  assert_cap_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> $past(smp_en));

  assert_quiet_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !cap_valid);

  assert_err_implies_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_done_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(arm));
endmodule

bind masked_trig_top masked_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en),
  .cap_valid(cap_valid), .done(done), .err(err)
);

// File: tb/tb_masked_trig_top.sv
`timescale 1ns/1ps
module tb_masked_trig_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        smp_en = 1'b0;
  logic [31:0] smp_data = '0;
  logic [31:0] cfg_mask = '0;
  logic [31:0] cfg_pattern = '0;
  logic        cfg_change_mode = 1'b0;
  logic        cfg_mismatch = 1'b0;
  logic        cfg_use_start = 1'b0;
  logic        cfg_stop_pattern = 1'b0;
  logic        cfg_start_fall = 1'b0;
  logic        cfg_stop_fall = 1'b0;
  logic        ext_start = 1'b0;
  logic        ext_stop = 1'b0;
  logic [15:0] cfg_pre = '0;
  logic [15:0] cfg_post = '0;
  logic        cap_valid;
  logic [31:0] cap_data;
  logic        done;
  logic        err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  masked_trig_top dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .smp_data(smp_data),
    .cfg_mask(cfg_mask), .cfg_pattern(cfg_pattern), .cfg_change_mode(cfg_change_mode),
    .cfg_mismatch(cfg_mismatch), .cfg_use_start(cfg_use_start),
    .cfg_stop_pattern(cfg_stop_pattern), .cfg_start_fall(cfg_start_fall),
    .cfg_stop_fall(cfg_stop_fall), .ext_start(ext_start), .ext_stop(ext_stop),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cap_valid(cap_valid), .cap_data(cap_data),
    .done(done), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One-clock strobe; result sampled on the following falling edge.
  task automatic strobe(input logic [31:0] d, input logic exp_cap, input string req);
    @(negedge clk);
    smp_en = 1'b1;
    smp_data = d;
    @(negedge clk);
    smp_en = 1'b0;
    check(req, {31'b0, cap_valid}, {31'b0, exp_cap});
    if (exp_cap) check(req, cap_data, d);
  endtask

  task automatic pulse_stop();
    @(negedge clk); ext_stop = 1'b1;
    @(negedge clk); ext_stop = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); arm = 1'b0;
    @(negedge clk);
    check("R1 disarm", {29'b0, cap_valid, done, err}, 32'b0);
    arm = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset", {29'b0, cap_valid, done, err}, 32'b0);
  endtask

  task automatic t_pattern_match();
    cfg_change_mode = 0; cfg_use_start = 0; cfg_stop_pattern = 1; cfg_mismatch = 0;
    cfg_mask = 32'hFF00_0000; cfg_pattern = 32'hAB00_0000; cfg_pre = 2; cfg_post = 2;
    rearm();
    strobe(32'h0000_0011, 1, "R2 free run");
    strobe(32'h0000_0022, 1, "R2 free run");
    strobe(32'hAB12_3456, 0, "R4 R10 match stop");
    strobe(32'h0000_0044, 1, "R8 post 1");
    strobe(32'h0000_0055, 1, "R8 post 2");
    check("R8 done", {30'b0, done, err}, 32'd2);
    strobe(32'h0000_0066, 0, "R8 no capture after done");
  endtask

  task automatic t_pattern_mismatch();
    cfg_mask = 32'h0000_00FF; cfg_pattern = 32'h0000_0042; cfg_mismatch = 1;
    cfg_pre = 0; cfg_post = 1;
    rearm();
    strobe(32'hFFFF_FF42, 1, "R4 R10 no mismatch");
    strobe(32'h0000_0043, 0, "R4 mismatch stop");
    strobe(32'h0000_0077, 1, "R8 post");
    check("R8 done mismatch", {30'b0, done, err}, 32'd2);
  endtask

  task automatic t_change();
    cfg_change_mode = 1; cfg_stop_pattern = 0; cfg_stop_fall = 0; cfg_mismatch = 0;
    cfg_mask = 32'h0000_000F; cfg_pre = 1; cfg_post = 1;
    rearm();
    strobe(32'h0000_00A0, 0, "R3 first sample loads");
    strobe(32'h0000_00F0, 0, "R10 masked change ignored");
    strobe(32'h0000_00F1, 1, "R3 change captured");
    pulse_stop();
    strobe(32'h0000_00F2, 0, "R5 rising stop");
    strobe(32'h0000_00F2, 0, "R3 no change");
    strobe(32'h1234_56F3, 1, "R3 full word");
    check("R8 done change", {30'b0, done, err}, 32'd2);
  endtask

  task automatic t_start_lag();
    cfg_change_mode = 0; cfg_use_start = 1; cfg_start_fall = 1; cfg_stop_pattern = 0;
    cfg_pre = 1; cfg_post = 1;
    rearm();
    strobe(32'h1, 0, "R6 waiting");
    pulse_stop();
    strobe(32'h2, 0, "R7 waiting");
    @(negedge clk); ext_start = 1'b1;
    strobe(32'h3, 0, "R5 wrong edge ignored");
    @(negedge clk); ext_start = 1'b0;
    strobe(32'h4, 0, "R6 sync strobe");
    strobe(32'h5, 1, "R6 R7 first capture");
    pulse_stop();
    strobe(32'h6, 0, "R7 stop after start");
    strobe(32'h7, 1, "R8 post");
    check("R8 done start", {30'b0, done, err}, 32'd2);
  endtask

  task automatic t_short_pre();
    cfg_use_start = 0; cfg_pre = 3; cfg_post = 2;
    rearm();
    strobe(32'h10, 1, "R9 pre sample");
    pulse_stop();
    strobe(32'h11, 0, "R9 stop early");
    check("R9 err done", {30'b0, done, err}, 32'd3);
    strobe(32'h12, 0, "R9 no capture");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pattern_match();
    t_pattern_mismatch();
    t_change();
    t_start_lag();
    t_short_pre();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule